// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Controller

This block is the digital front end of a two-channel current-output converter. A host shifts in a word made of a two-bit channel address followed by a data code. The word arrives serially on `sdi`, one bit per rising edge of `sclk`, while `csN` is low. When `csN` returns high, the address in the word selects which channel input register takes the data: channel A, channel B, both, or neither. Each channel has a second register that drives the parallel code output to the analog ladder. The active-low level strobe `loadN` copies both input registers into these output registers at the same time. This lets two channels be programmed one after the other and then updated together. If `loadN` is held low, a write reaches the output directly.

All pin activity is brought into the `clk` domain through synchronizers and then edge-detected. For this reason each level on `csN`, `sclk`, `sdi` and `loadN` must be held for at least three `clk` cycles. The active-low asynchronous reset `rstN` forces all four registers to a preset value. The `presetMid` pin chooses that value: zero scale or midscale. The reset also serves as the power-on preset.

Top module: `dual_dac_frontend`

## Requirements
- R1: While `rstN` is low with `presetMid` = 0, both input registers and both output registers are zero. After release, a load strobe still shows zero on both outputs.
- R2: While `rstN` is low with `presetMid` = 1, all four registers hold midscale, which is only the top data bit set (0x8000 for DATA_W = 16).
- R3: The serial word is DATA_W+2 bits long and is sent MSB first. Bits [DATA_W+1:DATA_W] of the captured word are the address and bits [DATA_W-1:0] are the data.
- R4: A bit is captured only on a rising edge of `sclk` while `csN` is low. `sclk` edges while `csN` is high leave the shift register unchanged.
- R5: When `csN` rises, only the most recent DATA_W+2 captured bits are used. Any earlier leading bits are dropped.
- R6: Address 01 writes the channel A input register only. Address 10 writes the channel B input register only.
- R7: Address 11 writes the same data into both input registers.
- R8: Address 00 writes neither input register.
- R9: While `loadN` is high, `codeA` and `codeB` hold their values even when the input registers are written.
- R10: While `loadN` is low, each output follows its input register within three `clk` cycles of the pin change, so a write reaches the output directly.
- R11: A `csN` rise after fewer than DATA_W+2 bits loads the current shift register contents. These are the older bits moved up by the new bits.
- R12: Reset overrides the load strobe and serial activity. Asserting `rstN` while `loadN` is low still forces the preset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for all registers |
| rstN | input | 1 | Asynchronous active-low reset and power-on preset |
| presetMid | input | 1 | Preset select: 0 gives zero scale, 1 gives midscale |
| csN | input | 1 | Active-low chip select; its rising edge commits the word |
| sclk | input | 1 | Serial bit clock; capture happens on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| loadN | input | 1 | Active-low level strobe that makes the output registers transparent |
| codeA | output | DATA_W | Channel A output register code |
| codeB | output | DATA_W | Channel B output register code |

## Verification
The input registers are hidden, so a wrong decode or a corrupted shift register appears at the ports only after a later load strobe. Checks therefore pair each write with a load pulse and compare both outputs, so that a stray write to the other channel is caught as well. A shift register that captures while `csN` is high, or that drops old bits, is revealed by a short word that lands on a channel and value depending on the previous word. Output registers that leak through without the strobe show up at once as a changed code while `loadN` is high.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
    logic loadThru;
  } dacStrobe_t;

  typedef enum logic [1:0] {
    ADDR_NONE = 2'b00,
    ADDR_A    = 2'b01,
    ADDR_B    = 2'b10,
    ADDR_BOTH = 2'b11
  } dacAddr_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{IDLE}};
      else       chain <= din;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{IDLE}};
      else       chain <= {chain[STAGES-2:0], din};
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       loadN,
  output dacStrobe_t strb
);
  localparam int PINS = 4;
  localparam logic [PINS-1:0] PIN_IDLE = 4'b1001;

  logic [PINS-1:0] pinSync;
  logic csS, sclkS, sdiS, loadS;
  logic csPrev, sclkPrev;

  dacfe_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({csN, sclk, sdi, loadN}),
    .dout (pinSync)
  );

  assign {csS, sclkS, sdiS, loadS} = pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  always_comb begin
    strb.shiftEn  = sclkS & ~sclkPrev & ~csS;
    strb.shiftBit = sdiS;
    strb.commit   = csS & ~csPrev;
    strb.loadThru = ~loadS;
  end

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit); // R3
endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] presetVal,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadThru,
  output logic [DATA_W-1:0] inVal,
  output logic [DATA_W-1:0] code
);
  logic [DATA_W-1:0] inReg, dacReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg  <= presetVal;
      dacReg <= presetVal;
    end else begin
      if (wrEn)     inReg  <= wrData;
      if (loadThru) dacReg <= inReg;
    end
  end

  assign inVal = inReg;
  assign code  = dacReg;

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dacReg != $past(dacReg)) |-> $past(loadThru)); // R9
  AST_DAC_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadThru) |-> (dacReg == $past(inReg))); // R10
  AST_IN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (inReg != $past(inReg)) |-> $past(wrEn)); // R8
endmodule

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              presetMid,
  input  dacStrobe_t        strb,
  output logic [DATA_W-1:0] codeA,
  output logic [DATA_W-1:0] codeB
);
  localparam int WORD_W = DATA_W + 2;
  localparam int CHANS = 2;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [DATA_W-1:0] presetVal;
  logic [DATA_W-1:0] wordData;
  dacAddr_t          wordAddr;
  logic [CHANS-1:0]  chanSel;
  logic [DATA_W-1:0] chanIn   [CHANS];
  logic [DATA_W-1:0] chanCode [CHANS];

  assign presetVal = presetMid ? MID_CODE : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strb.shiftBit};
  end

  assign wordAddr = dacAddr_t'(shiftReg[WORD_W-1 -: 2]);
  assign wordData = shiftReg[DATA_W-1:0];

  always_comb begin
    chanSel = '0;
    unique case (wordAddr)
      ADDR_A:    chanSel = 2'b01;
      ADDR_B:    chanSel = 2'b10;
      ADDR_BOTH: chanSel = 2'b11;
      default:   chanSel = 2'b00;
    endcase
  end

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    dacfe_channel #(.DATA_W(DATA_W)) i_chan (
      .clk       (clk),
      .rstN      (rstN),
      .presetVal (presetVal),
      .wrEn      (strb.commit & chanSel[ch]),
      .wrData    (wordData),
      .loadThru  (strb.loadThru),
      .inVal     (chanIn[ch]),
      .code      (chanCode[ch])
    );
  end

  assign codeA = chanCode[0];
  assign codeB = chanCode[1];

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.shiftEn) |-> (shiftReg == $past(shiftReg))); // R4
  AST_NONE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && wordAddr == ADDR_NONE) |->
      (chanIn[0] == $past(chanIn[0])) && (chanIn[1] == $past(chanIn[1]))); // R8
  AST_BROADCAST: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && wordAddr == ADDR_BOTH) |-> (chanIn[0] == chanIn[1])); // R7
  AST_SINGLE_A: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && wordAddr == ADDR_A) |->
      (chanIn[0] == $past(wordData)) && (chanIn[1] == $past(chanIn[1]))); // R6
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              presetMid,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              loadN,
  output logic [DATA_W-1:0] codeA,
  output logic [DATA_W-1:0] codeB
);
  dacStrobe_t strb;

  dacfe_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sclk  (sclk),
    .sdi   (sdi),
    .loadN (loadN),
    .strb  (strb)
  );

  dacfe_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .presetMid (presetMid),
    .strb      (strb),
    .codeA     (codeA),
    .codeB     (codeB)
  );
endmodule

// File: tb/test_dual_dac_frontend.sv
module test_dual_dac_frontend;
  localparam int DATA_W = 16;
  localparam int WORD_W = DATA_W + 2;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic presetMid = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic loadN = 1'b1;
  logic [DATA_W-1:0] codeA, codeB;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [WORD_W-1:0] expSr = '0;
  logic [DATA_W-1:0] expInA = '0, expInB = '0, expDacA = '0, expDacB = '0;

  always #5 clk = ~clk;

  dual_dac_frontend #(.DATA_W(DATA_W)) i_dual_dac_frontend (
    .clk(clk), .rstN(rstN), .presetMid(presetMid), .csN(csN),
    .sclk(sclk), .sdi(sdi), .loadN(loadN), .codeA(codeA), .codeB(codeB)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBoth(input string req);
    check({req, " codeA"}, codeA, expDacA);
    check({req, " codeB"}, codeB, expDacB);
  endtask

  task automatic shiftBit(input bit b, input bit capture);
    sdi = b;
    waitClk(HOLD);
    sclk = 1'b1;
    waitClk(HOLD);
    sclk = 1'b0;
    if (capture) expSr = {expSr[WORD_W-2:0], b};
  endtask

  function automatic void commitModel();
    logic [1:0] a;
    a = expSr[WORD_W-1 -: 2];
    if (a[0]) expInA = expSr[DATA_W-1:0];
    if (a[1]) expInB = expSr[DATA_W-1:0];
    if (!loadN) begin
      expDacA = expInA;
      expDacB = expInB;
    end
  endfunction

  task automatic writeBits(input logic [31:0] val, input int n);
    csN = 1'b0;
    waitClk(HOLD);
    for (int i = n - 1; i >= 0; i--) shiftBit(val[i], 1'b1);
    waitClk(HOLD);
    csN = 1'b1;
    waitClk(8);
    commitModel();
  endtask

  task automatic pulseLoad();
    loadN = 1'b0;
    waitClk(8);
    loadN = 1'b1;
    waitClk(8);
    expDacA = expInA;
    expDacB = expInB;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    waitClk(5);
    checkBoth("R1 reset zero");
    rstN = 1'b1;
    waitClk(3);
    pulseLoad();
    checkBoth("R1 inputs zero after load");

    writeBits({14'd0, 2'b01, 16'h1234}, WORD_W);
    checkBoth("R9 hold after A write");
    writeBits({14'd0, 2'b10, 16'hBEEF}, WORD_W);
    checkBoth("R9 hold after B write");
    pulseLoad();
    check("R6 R3 channel A", codeA, 16'h1234);
    check("R6 R10 channel B", codeB, 16'hBEEF);

    writeBits({14'd0, 2'b00, 16'h5555}, WORD_W);
    pulseLoad();
    checkBoth("R8 address none");

    writeBits({14'd0, 2'b11, 16'h0F0F}, WORD_W);
    pulseLoad();
    check("R7 broadcast A", codeA, 16'h0F0F);
    check("R7 broadcast B", codeB, 16'h0F0F);

    writeBits({8'd0, 6'b101101, 2'b01, 16'hA5C3}, WORD_W + 6);
    pulseLoad();
    check("R5 leading bits dropped", codeA, 16'hA5C3);
    check("R5 B untouched", codeB, 16'h0F0F);

    for (int i = 0; i < 5; i++) shiftBit(1'b1, 1'b0);
    writeBits(32'b1001, 4);
    pulseLoad();
    check("R4 R11 short word B", codeB, 16'h5C39);
    check("R11 short word A", codeA, 16'hA5C3);

    loadN = 1'b0;
    waitClk(8);
    writeBits({14'd0, 2'b01, 16'h7777}, WORD_W);
    check("R10 single-buffered A", codeA, 16'h7777);

    rstN = 1'b0;
    presetMid = 1'b1;
    waitClk(4);
    check("R2 R12 midscale A in reset", codeA, 16'h8000);
    check("R2 R12 midscale B in reset", codeB, 16'h8000);
    rstN = 1'b1;
    expSr = '0;
    expInA = 16'h8000; expInB = 16'h8000; expDacA = 16'h8000; expDacB = 16'h8000;
    waitClk(6);
    checkBoth("R2 inputs midscale");
    loadN = 1'b1;
    waitClk(6);

    for (int k = 0; k < 24; k++) begin
      logic [1:0] a;
      logic [DATA_W-1:0] d;
      logic [5:0] junk;
      int extra;
      a = 2'($urandom % 4);
      d = DATA_W'($urandom);
      junk = 6'($urandom);
      extra = int'($urandom % 7);
      writeBits({8'd0, junk, a, d}, WORD_W + extra);
      checkBoth("R9 random hold");
      if ($urandom % 2 == 1) begin
        pulseLoad();
        checkBoth("R3 random word");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule